// File: doc/BRIEF.md
# Handshaked FIFO with occupancy flags

This block is a first-in first-out word buffer with a strobe handshake on each side. A producer pulses `shift_in` for one clock while `in_ready` is high to store the word on `din`. A consumer sees the oldest stored word on `dout` whenever `out_ready` is high. No read command is needed to present it. A one-cycle pulse on `shift_out` discards that word and moves the next one forward. Strobes that arrive when the matching ready is low have no effect.

Two occupancy flags give a coarse fill level without a word count. `afe_flag` is high when the buffer is nearly drained or nearly full. `hf_flag` is high when the buffer holds half its capacity or more. `oe` gates only the data output: when it is low, `dout` is driven to zero and the buffer state is untouched. `rst_n` is an active-low master reset.

All logic is synchronous to one clock. The depth defaults to 64 words and the width to 9 bits, and both are set by parameter.

Top module: `fifo_hs`

## Requirements
- R1: While `rst_n` is low, `in_ready`=1, `out_ready`=0, `afe_flag`=1, `hf_flag`=0 and `dout`=0.
- R2: `in_ready` is high exactly when fewer than 64 words are stored. A `shift_in` pulse while `in_ready` is low changes neither the stored words nor the count.
- R3: `out_ready` is high exactly when at least one word is stored. A `shift_out` pulse while `out_ready` is low changes nothing.
- R4: Words leave in the order they were accepted. While `out_ready` and `oe` are high, `dout` equals the oldest stored word, including a word that was just written into an empty buffer.
- R5: With 1 to 63 words stored, `shift_in` and `shift_out` in the same cycle both take effect and the count is unchanged. With 0 words stored, only the write takes effect. With 64 words stored, only the read takes effect.
- R6: `afe_flag` is 1 for 0 to 8 stored words and for 56 to 64 stored words, and 0 for 9 to 55 stored words.
- R7: `hf_flag` is 1 for 32 to 64 stored words and 0 for 0 to 31. It rises only on an accepted write and falls only on an accepted read.
- R8: `in_ready`, `out_ready`, `afe_flag`, `hf_flag` and `dout` all reflect an accepted strobe right after the clock edge that samples it.
- R9: While `oe` is low, `dout` is all zeros, and the buffer contents and count are unaffected.
- R10: While no word is stored, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_in | input | 1 | One-cycle write strobe |
| din | input | WIDTH | Word to store |
| in_ready | output | 1 | Buffer can accept a word |
| shift_out | input | 1 | One-cycle strobe that discards the head word |
| out_ready | output | 1 | A head word is present on `dout` |
| oe | input | 1 | Output enable; low forces `dout` to zero |
| dout | output | WIDTH | Oldest stored word |
| afe_flag | output | 1 | Nearly empty or nearly full |
| hf_flag | output | 1 | Half full or more |

## Verification
Every state-dependent output is due one edge after the strobe that changes it. The count, both readies and both flags are registered on the sampling edge, and `dout` follows combinationally from the new read position. The exception is `oe`, which acts on `dout` within the same cycle with no edge in between. The bench drives strobes and data at the falling edge. It waits for the next rising edge, updates its queue model, and compares all outputs one time unit later. For this reason no check depends on the order of processes at the edge. The sweep walks the fill level through every value from 0 to 64 and back down. That walk covers each flag boundary in both directions. Mixed and random strobe patterns follow the sweep.

// File: rtl/fifo_hs_pkg.sv
package fifo_hs_pkg;

  // Edge flag: true near either end of the occupancy range.
  function automatic logic afe_of(input int unsigned n,
                                  input int unsigned depth,
                                  input int unsigned gap);
    return (n <= gap) || (n >= depth - gap);
  endfunction

  // Half flag: true at half capacity or above.
  function automatic logic hf_of(input int unsigned n,
                                 input int unsigned depth);
    return n >= depth / 2;
  endfunction

endpackage

// File: rtl/fifo_hs_ctrl.sv
module fifo_hs_ctrl #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_in,
  input  logic          shift_out,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          in_ready,
  output logic          out_ready
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  // Readiness is a decode of the registered count.
  assign in_ready  = (count != FULL_CNT);
  assign out_ready = (count != '0);

  // A strobe is accepted only when the matching side is ready.
  assign wr_acc = shift_in  & in_ready;
  assign rd_acc = shift_out & out_ready;

  always_comb begin
    unique case ({wr_acc, rd_acc})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      count <= count_nxt;
      if (wr_acc) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (rd_acc) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R2
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_in && !in_ready && !shift_out) |=> $stable(count));

  // R3
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_out && !out_ready && !shift_in) |=> $stable(count));

  // R5
  both_keep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_acc) |=> $stable(count));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rd_acc) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/fifo_hs_store.sv
module fifo_hs_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9,
  parameter int PW    = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_ptr,
  input  logic [WIDTH-1:0] wr_word,
  input  logic [PW-1:0]    rd_ptr,
  output logic [WIDTH-1:0] rd_word
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Storage needs no reset: the top gates the output while the buffer is empty.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  // Fall-through read port: the head word is visible without a command.
  assign rd_word = mem[rd_ptr];

endmodule

// File: rtl/fifo_hs_flags.sv
module fifo_hs_flags #(
  parameter int DEPTH = 64,
  parameter int GAP   = 8,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] count_nxt,
  input  logic          wr_acc,
  input  logic          rd_acc,
  output logic          afe_flag,
  output logic          hf_flag
);
  import fifo_hs_pkg::*;

  // Flags are decoded from the next count, so they change on the same edge as the count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      afe_flag <= 1'b1;
      hf_flag  <= 1'b0;
    end else begin
      afe_flag <= afe_of(int'(count_nxt), DEPTH, GAP);
      hf_flag  <= hf_of(int'(count_nxt), DEPTH);
    end
  end

  // R6
  afe_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    afe_flag == afe_of(int'(count), DEPTH, GAP));

  // R7
  hf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hf_flag) |-> $past(wr_acc));

  // R7
  hf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hf_flag) |-> $past(rd_acc));

endmodule

// File: rtl/fifo_hs.sv
module fifo_hs #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9,
  parameter int GAP   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  input  logic             oe,
  output logic [WIDTH-1:0] dout,
  output logic             afe_flag,
  output logic             hf_flag
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic          wr_acc;
  logic          rd_acc;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic [CW-1:0] count_nxt;
  logic [WIDTH-1:0] head_word;

  fifo_hs_ctrl #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .shift_out(shift_out),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .count_nxt(count_nxt),
    .in_ready(in_ready), .out_ready(out_ready)
  );

  fifo_hs_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) store_i (
    .clk(clk), .wr_en(wr_acc), .wr_ptr(wr_ptr), .wr_word(din),
    .rd_ptr(rd_ptr), .rd_word(head_word)
  );

  fifo_hs_flags #(.DEPTH(DEPTH), .GAP(GAP), .CW(CW)) flags_i (
    .clk(clk), .rst_n(rst_n), .count(count), .count_nxt(count_nxt),
    .wr_acc(wr_acc), .rd_acc(rd_acc),
    .afe_flag(afe_flag), .hf_flag(hf_flag)
  );

  // Output is zero when disabled or when there is no head word.
  assign dout = (oe && out_ready) ? head_word : '0;

  // R4
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && out_ready && !rd_acc) |=> (!oe || dout == $past(dout)));

  // R9
  oe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dout == '0));

  // R10
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (dout == '0));

endmodule

// File: tb/fifo_hs_tb.sv
module fifo_hs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int WIDTH = 9;
  localparam int GAP   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_in = 1'b0;
  logic shift_out = 1'b0;
  logic oe = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic in_ready, out_ready, afe_flag, hf_flag;
  logic [WIDTH-1:0] dout;

  int n_tests = 0;
  int n_fail  = 0;
  logic [WIDTH-1:0] model[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_hs dut_i (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din),
    .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
    .oe(oe), .dout(dout), .afe_flag(afe_flag), .hf_flag(hf_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected outputs restated arithmetically from the requirements.
  task automatic compare(input string ctx);
    int n;
    int exp_out;
    n = model.size();
    check({"R2 in_ready ", ctx}, int'(in_ready), int'(n < DEPTH));
    check({"R3 out_ready ", ctx}, int'(out_ready), int'(n > 0));
    check({"R6 afe_flag ", ctx}, int'(afe_flag), int'((n <= GAP) || (n >= DEPTH - GAP)));
    check({"R7 hf_flag ", ctx}, int'(hf_flag), int'(n >= DEPTH / 2));
    exp_out = (oe && n > 0) ? int'(model[0]) : 0;
    check({"R4/R9/R10 dout ", ctx}, int'(dout), exp_out);
  endtask

  // One cycle: drive at the falling edge, let the rising edge sample, check after it (R8).
  task automatic step(input logic si, input logic so, input logic [WIDTH-1:0] d,
                      input logic oe_v, input string ctx);
    bit w;
    bit r;
    @(negedge clk);
    shift_in = si; shift_out = so; din = d; oe = oe_v;
    @(posedge clk);
    w = si && (model.size() < DEPTH);
    r = so && (model.size() > 0);
    if (r) void'(model.pop_front());
    if (w) model.push_back(d);
    #1;
    compare(ctx);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] w;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 out_ready", int'(out_ready), 0);
    check("R1 afe_flag", int'(afe_flag), 1);
    check("R1 hf_flag", int'(hf_flag), 0);
    check("R1 dout", int'(dout), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill through every level: crosses 8/9, 31/32, 55/56 upward (R6, R7).
    for (int i = 0; i < DEPTH; i++) begin
      w = WIDTH'((i * 37 + 5) % 512);
      step(1'b1, 1'b0, w, 1'b1, "fill");
    end
    // R2: writes while full are ignored
    step(1'b1, 1'b0, 9'h1AA, 1'b1, "R2 full write");
    step(1'b1, 1'b0, 9'h155, 1'b1, "R2 full write");
    // R9: oe low hides data, leaves state alone
    step(1'b0, 1'b0, '0, 1'b0, "R9 oe low");
    step(1'b0, 1'b0, '0, 1'b1, "R9 oe restored");
    // Drain: order and downward boundaries (R4, R6, R7)
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, '0, 1'b1, "drain");
    // R3: read while empty ignored
    step(1'b0, 1'b1, '0, 1'b1, "R3 empty read");
    // R5: both at empty -> only write
    step(1'b1, 1'b1, 9'h0C3, 1'b1, "R5 both at empty");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, WIDTH'(i + 100), 1'b1, "R5 prefill");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, WIDTH'(i + 300), 1'b1, "R5 both mid");
    while (model.size() < DEPTH) step(1'b1, 1'b0, WIDTH'(model.size() + 7), 1'b1, "R5 refill");
    // R5: both at full -> only read
    step(1'b1, 1'b1, 9'h1FF, 1'b1, "R5 both at full");
    step(1'b1, 1'b1, 9'h0F0, 1'b1, "R5 both near full");

    // Random strobes with shifting bias so the level wanders end to end.
    for (int ph = 0; ph < 6; ph++) begin
      int pw;
      pw = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 15 : 50;
      for (int i = 0; i < 400; i++) begin
        logic si_v, so_v, oe_v;
        si_v = ($urandom % 100) < pw;
        so_v = ($urandom % 100) < (100 - pw);
        oe_v = ($urandom % 10) != 0;
        step(si_v, so_v, WIDTH'($urandom), oe_v, "random");
      end
    end
    while (model.size() > 0) step(1'b0, 1'b1, '0, 1'b1, "final drain");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule